// File: doc/BRIEF.md
# Bridge PWM Output Steering

This block produces one pulse-width modulated waveform and steers it onto four output pins, A to D, for single-ended, half-bridge or full-bridge power stages. A free-running count made of an 8-bit period timer and a 2-bit fine prescale gives 10-bit duty resolution. The output is active from the start of each period until the count reaches the duty value. Mode, bridge topology, period, duty and dead time are sampled into shadow registers at each period boundary, so a change never cuts a pulse short.

In half-bridge mode, pins A and B carry complementary copies of the waveform. A programmable number of clocks is inserted before either of them turns on. The two full-bridge modes hold one diagonal of the bridge on and modulate the other, and each mode direction drives the motor one way. A shutdown request forces every driven pin to its inactive level. A sticky status flag records the event. The outputs return at a period boundary, after the flag clears either by itself or on a software restart pulse.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The internal count runs from 0 to 4*P+3 and then wraps to 0, where P is the latched 8-bit period. One period therefore lasts 4*(P+1) clocks.
- R2: The modulated signal is active while the count is below the latched 10-bit duty, formed as {duty_hi_i, duty_lo_i}. A duty of 0 is never active, and a duty of 4*(P+1) or more is always active. Pins are registered and follow the count by one clock.
- R3: Period, duty, mode, bridge and dead time are latched only at the clock edge where the count wraps to 0. Reset clears all of them, so the first wrap comes 4 clocks after reset.
- R4: When mode[3:2] is not 11, all pin enables are 0 and all pins drive 0. This is also the state after reset.
- R5: Bridge 00 (single): only pin A is enabled (pin_en_o = 0001) and it carries the waveform.
- R6: Bridge 01 (full forward): all four pins are enabled. D carries the waveform, A is held active, and B and C are held inactive.
- R7: Bridge 10 (half): only A and B are enabled. A carries the waveform and B its complement. Each turn-on of A or B is delayed by the latched dead-time count of clocks after the other pin's turn-off, so both are never active together.
- R8: Bridge 11 (full reverse): all four pins are enabled. B carries the waveform, C is held active, and A and D are held inactive.
- R9: Pin bit order is pin_o[0]=A, [1]=B, [2]=C, [3]=D. Mode bit 1 makes the A/C pair active low, and mode bit 0 makes the B/D pair active low.
- R10: While shut_i is high, every enabled pin goes to its inactive level at the next clock edge and shut_stat_o is set.
- R11: With auto_restart_i high, shut_stat_o clears on the first clock after shut_i falls. The pins resume at the first period wrap that finds the flag already clear.
- R12: With auto_restart_i low, shut_stat_o and the forced-off pins persist until restart_i is pulsed while shut_i is low. The pins then resume at the following period wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 8 | Period value P |
| duty_hi_i | input | 8 | Upper duty bits |
| duty_lo_i | input | 2 | Lower duty bits |
| mode_i | input | 4 | [3:2]=11 enables PWM; [1] A/C active low; [0] B/D active low |
| bridge_i | input | 2 | Output topology select |
| dead_i | input | 7 | Half-bridge dead time in clocks |
| shut_i | input | 1 | Shutdown request |
| auto_restart_i | input | 1 | Clear shutdown status automatically |
| restart_i | input | 1 | Software clear of shutdown status |
| pin_o | output | 4 | Pin drive levels, D..A |
| pin_en_o | output | 4 | Pin is PWM-driven (1) or general I/O (0) |
| shut_stat_o | output | 1 | Sticky shutdown status |

## Verification
The bench targets duty values of 0, exactly one period and above one period. A wrong comparison shows up there as a one-clock sliver or a missing pulse. It changes duty in the middle of a pulse, which a design without shadow registers would truncate. It measures the gap between B falling and A rising in half-bridge mode, which exposes a dead-time counter that is off by one or skipped. It also times the release from shutdown against the period wrap, in both automatic and manual restart, so that a design which resumes mid-period or ignores the restart pulse is caught.

// File: rtl/pwm_bridge_pkg.sv
package pwm_bridge_pkg;

  typedef enum logic [1:0] {
    BR_SINGLE = 2'b00,
    BR_FWD    = 2'b01,
    BR_HALF   = 2'b10,
    BR_REV    = 2'b11
  } bridge_e;

  // Pin order inside every vector: [3]=D [2]=C [1]=B [0]=A
  typedef struct packed {
    logic [3:0] en;
    logic [3:0] act;
  } steer_t;

  // Logical (pre-polarity) activity and enables for one topology
  function automatic steer_t steer_map(input bridge_e br, input logic raw,
                                       input logic a_on, input logic b_on);
    steer_t s;
    case (br)
      BR_SINGLE: begin s.en = 4'b0001; s.act = {3'b000, raw};            end
      BR_FWD:    begin s.en = 4'b1111; s.act = {raw, 1'b0, 1'b0, 1'b1};  end
      BR_HALF:   begin s.en = 4'b0011; s.act = {2'b00, b_on, a_on};      end
      default:   begin s.en = 4'b1111; s.act = {1'b0, 1'b1, raw, 1'b0};  end
    endcase
    return s;
  endfunction

  // Inversion mask: bit1 of pol flips A and C, bit0 flips B and D
  function automatic logic [3:0] pol_mask(input logic [1:0] pol);
    return {pol[0], pol[1], pol[0], pol[1]};
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8,
  parameter int PRE_W = 2,
  parameter int DB_W  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TMR_W-1:0]       period_i,
  input  logic [TMR_W+PRE_W-1:0] duty_i,
  input  logic [3:0]             mode_i,
  input  logic [1:0]             bridge_i,
  input  logic [DB_W-1:0]        dead_i,
  output logic                   wrap_o,
  output logic                   raw_o,
  output logic [3:0]             mode_o,
  output logic [1:0]             bridge_o,
  output logic [DB_W-1:0]        dead_o
);
  localparam int CNT_W = TMR_W + PRE_W;

  logic [CNT_W-1:0] cnt_q, duty_q, last_w;
  logic [TMR_W-1:0] per_q;

  function automatic logic [CNT_W-1:0] period_last(input logic [TMR_W-1:0] p);
    return {p, {PRE_W{1'b1}}};
  endfunction

  function automatic logic duty_active(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  assign last_w = period_last(per_q);
  assign wrap_o = (cnt_q == last_w);
  assign raw_o  = duty_active(cnt_q, duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      per_q    <= '0;
      duty_q   <= '0;
      mode_o   <= '0;
      bridge_o <= '0;
      dead_o   <= '0;
    end else if (wrap_o) begin
      cnt_q    <= '0;
      per_q    <= period_i;
      duty_q   <= duty_i;
      mode_o   <= mode_i;
      bridge_o <= bridge_i;
      dead_o   <= dead_i;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_w); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable({per_q, duty_q, mode_o, bridge_o, dead_o})); // R3

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic [DB_W-1:0] dead_i,
  output logic            a_on_o,
  output logic            b_on_o
);
  logic            prev_q, edge_w, gap_ok_w;
  logic [DB_W-1:0] run_q, run_w;

  assign edge_w   = raw_i ^ prev_q;
  assign run_w    = edge_w ? '0 : run_q;
  assign gap_ok_w = (run_w >= dead_i);
  assign a_on_o   = raw_i  & gap_ok_w;
  assign b_on_o   = ~raw_i & gap_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '1;
    end else begin
      prev_q <= raw_i;
      if (edge_w)
        run_q <= {{(DB_W-1){1'b0}}, 1'b1};
      else if (run_q != '1)
        run_q <= run_q + 1'b1;
    end
  end

  AST_DB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_on_o && b_on_o)); // R7

  AST_DB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_on_o) && dead_i != '0) |-> !$past(b_on_o)); // R7

endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_i,
  input  logic auto_i,
  input  logic restart_i,
  input  logic wrap_i,
  output logic stat_o,
  output logic force_o
);
  logic kill_q;

  assign force_o = shut_i | kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      if (shut_i)
        stat_o <= 1'b1;
      else if (auto_i || restart_i)
        stat_o <= 1'b0;
      if (shut_i)
        kill_q <= 1'b1;
      else if (wrap_i && !stat_o)
        kill_q <= 1'b0;
    end
  end

  AST_SHUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    shut_i |=> (stat_o && kill_q)); // R10

  AST_RELEASE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kill_q) |-> $past(wrap_i)); // R11

  AST_MANUAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !auto_i && !restart_i) |=> stat_o); // R12

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic [1:0] bridge_i,
  input  logic       raw_i,
  input  logic       a_on_i,
  input  logic       b_on_i,
  input  logic       force_i,
  output logic [3:0] pin_o,
  output logic [3:0] en_o
);
  steer_t     map_w;
  logic       pwm_w;
  logic [3:0] inv_w, act_w, en_w;

  assign pwm_w = (mode_i[3:2] == 2'b11);
  assign map_w = steer_map(bridge_e'(bridge_i), raw_i, a_on_i, b_on_i);
  assign inv_w = pol_mask(mode_i[1:0]);
  assign en_w  = pwm_w ? map_w.en : 4'b0000;
  assign act_w = (pwm_w && !force_i) ? map_w.act : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o <= '0;
      en_o  <= '0;
    end else begin
      pin_o <= (act_w ^ inv_w) & en_w;
      en_o  <= en_w;
    end
  end

  AST_SHUT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> (pin_o == ($past(inv_w) & en_o))); // R10

  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_w |=> (en_o == 4'b0000 && pin_o == 4'b0000)); // R4

  AST_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_w && bridge_i == 2'b10) |=> (((pin_o ^ $past(inv_w)) & 4'b0011) != 4'b0011)); // R7

endmodule

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer #(
  parameter int TMR_W = 8,
  parameter int PRE_W = 2,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TMR_W-1:0] duty_hi_i,
  input  logic [PRE_W-1:0] duty_lo_i,
  input  logic [3:0]       mode_i,
  input  logic [1:0]       bridge_i,
  input  logic [DB_W-1:0]  dead_i,
  input  logic             shut_i,
  input  logic             auto_restart_i,
  input  logic             restart_i,
  output logic [3:0]       pin_o,
  output logic [3:0]       pin_en_o,
  output logic             shut_stat_o
);
  logic            wrap_w, raw_w, a_on_w, b_on_w, force_w;
  logic [3:0]      mode_sh;
  logic [1:0]      bridge_sh;
  logic [DB_W-1:0] dead_sh;

  pwm_timebase #(.TMR_W(TMR_W), .PRE_W(PRE_W), .DB_W(DB_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .duty_i   ({duty_hi_i, duty_lo_i}),
    .mode_i   (mode_i),
    .bridge_i (bridge_i),
    .dead_i   (dead_i),
    .wrap_o   (wrap_w),
    .raw_o    (raw_w),
    .mode_o   (mode_sh),
    .bridge_o (bridge_sh),
    .dead_o   (dead_sh)
  );

  pwm_deadband #(.DB_W(DB_W)) u_db (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_w),
    .dead_i (dead_sh),
    .a_on_o (a_on_w),
    .b_on_o (b_on_w)
  );

  pwm_shutdown u_sd (
    .clk       (clk),
    .rst_n     (rst_n),
    .shut_i    (shut_i),
    .auto_i    (auto_restart_i),
    .restart_i (restart_i),
    .wrap_i    (wrap_w),
    .stat_o    (shut_stat_o),
    .force_o   (force_w)
  );

  pwm_steer u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_sh),
    .bridge_i (bridge_sh),
    .raw_i    (raw_w),
    .a_on_i   (a_on_w),
    .b_on_i   (b_on_w),
    .force_i  (force_w),
    .pin_o    (pin_o),
    .en_o     (pin_en_o)
  );

endmodule

// File: tb/pwm_bridge_steer_test.sv
`timescale 1ns/1ps
module pwm_bridge_steer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_i = '0;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic [3:0] mode_i = '0;
  logic [1:0] bridge_i = '0;
  logic [6:0] dead_i = '0;
  logic       shut_i = 1'b0;
  logic       auto_restart_i = 1'b1;
  logic       restart_i = 1'b0;
  logic [3:0] pin_o, pin_en_o;
  logic       shut_stat_o;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc_cnt = 0;
  string cur_tag = "R4";

  // reference model state
  int         m_cnt, m_per, m_duty, m_dead, m_run;
  logic [3:0] m_mode;
  logic [1:0] m_bridge;
  bit         m_prev, m_stat, m_kill;
  logic [3:0] exp_pin, exp_en;
  bit         exp_stat;

  pwm_bridge_steer uut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_hi_i(duty_hi_i),
    .duty_lo_i(duty_lo_i), .mode_i(mode_i), .bridge_i(bridge_i), .dead_i(dead_i),
    .shut_i(shut_i), .auto_restart_i(auto_restart_i), .restart_i(restart_i),
    .pin_o(pin_o), .pin_en_o(pin_en_o), .shut_stat_o(shut_stat_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_cnt++;

  function automatic logic [3:0] inv_of(input logic [3:0] md);
    // R9: A,C follow mode bit 1; B,D follow mode bit 0
    logic [3:0] v;
    v[0] = md[1]; v[2] = md[1];
    v[1] = md[0]; v[3] = md[0];
    return v;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_per = 0; m_duty = 0; m_dead = 0; m_run = 127;
    m_mode = '0; m_bridge = '0; m_prev = 0; m_stat = 0; m_kill = 0;
    exp_pin = '0; exp_en = '0; exp_stat = 0;
  endtask

  task automatic model_step();
    int         span, run_eff;
    bit         on, chg, a_on, b_on, force_off, wrap;
    logic [3:0] act, en;
    span    = 4 * (m_per + 1);
    on      = (m_cnt < m_duty);
    chg     = (on != m_prev);
    run_eff = chg ? 0 : m_run;
    a_on    = on && (run_eff >= m_dead);
    b_on    = !on && (run_eff >= m_dead);
    unique case (m_bridge)
      2'd0: begin en = 4'b0001; act = {3'b000, on}; end
      2'd1: begin en = 4'b1111; act = {on, 2'b00, 1'b1}; end
      2'd2: begin en = 4'b0011; act = {2'b00, b_on, a_on}; end
      default: begin en = 4'b1111; act = {1'b0, 1'b1, on, 1'b0}; end
    endcase
    force_off = shut_i || m_kill;
    if (m_mode[3:2] != 2'b11) begin en = '0; act = '0; end
    if (force_off) act = '0;
    exp_pin = (act ^ inv_of(m_mode)) & en;
    exp_en  = en;
    wrap = (m_cnt == span - 1);
    if (shut_i) m_kill = 1; else if (wrap && !m_stat) m_kill = 0;
    if (shut_i) m_stat = 1; else if (auto_restart_i || restart_i) m_stat = 0;
    exp_stat = m_stat;
    m_prev = on;
    m_run  = chg ? 1 : (m_run < 127 ? m_run + 1 : 127);
    if (wrap) begin
      m_cnt = 0; m_per = period_i; m_duty = {duty_hi_i, duty_lo_i};
      m_mode = mode_i; m_bridge = bridge_i; m_dead = dead_i;
    end else m_cnt++;
  endtask

  // cycle-accurate comparison, outputs sampled at the falling edge
  always @(negedge clk) begin
    n_chk++;
    if ({pin_o, pin_en_o, shut_stat_o} !== {exp_pin, exp_en, exp_stat}) begin
      n_err++;
      $display("FAIL %s cycle %0d pin=%b/%b en=%b/%b stat=%b/%b (actual/expected)",
               cur_tag, cyc_cnt, pin_o, exp_pin, pin_en_o, exp_en, shut_stat_o, exp_stat);
    end
    if (!rst_n) model_reset(); else model_step();
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic slot();
    @(posedge clk); #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) slot();
  endtask

  task automatic setp(input logic [3:0] md, input logic [1:0] br, input int per,
                      input int duty, input int dead);
    mode_i = md; bridge_i = br; period_i = per[7:0];
    duty_hi_i = duty[9:2]; duty_lo_i = duty[1:0]; dead_i = dead[6:0];
  endtask

  task automatic wait_edge(input int idx, input bit rising);
    logic p;
    @(negedge clk); p = pin_o[idx];
    forever begin
      @(negedge clk);
      if (pin_o[idx] == rising && p != rising) break;
      p = pin_o[idx];
    end
  endtask

  task automatic hold_check(input string tag, input int n, input logic [3:0] pins);
    repeat (n) begin
      @(negedge clk);
      chk(tag, pin_o, pins);
    end
  endtask

  function automatic string tag_of(input logic [3:0] md, input logic [1:0] br);
    if (md[3:2] != 2'b11) return "R4";
    case (br)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int t1, t2, w;
    void'($urandom(32'd20240611));
    @(negedge clk);
    cur_tag = "R4";
    chk("R4 reset pins", pin_o, 0);
    chk("R4 reset enables", pin_en_o, 0);
    chk("R4 reset status", shut_stat_o, 0);
    wait_cyc(3);
    rst_n = 1'b1;

    // R1 / R2: single output, P=3, duty=1 -> 1-clock pulse every 16 clocks
    cur_tag = "R1";
    setp(4'b1100, 2'b00, 3, 1, 0);
    wait_cyc(40);
    wait_edge(0, 1'b1); t1 = cyc_cnt;
    wait_edge(0, 1'b1); t2 = cyc_cnt;
    chk("R1 period length", t2 - t1, 16);
    w = 1;
    forever begin @(negedge clk); if (!pin_o[0]) break; w++; end
    chk("R2 pulse width duty=1", w, 1);
    chk("R5 single enables", pin_en_o, 4'b0001);

    // R3: duty changed mid-pulse must not shorten the running pulse
    slot(); cur_tag = "R3";
    setp(4'b1100, 2'b00, 7, 16, 0);
    wait_cyc(80);
    wait_edge(0, 1'b1);
    slot(); duty_hi_i = '0; duty_lo_i = '0;
    w = 1;
    forever begin @(negedge clk); if (!pin_o[0]) break; w++; end
    chk("R3 pulse kept after mid-period change", w, 16);
    hold_check("R2 duty 0 never active", 40, 4'b0000);

    // R2: duty above period -> always active
    slot(); cur_tag = "R2";
    setp(4'b1100, 2'b00, 3, 1023, 0);
    wait_cyc(40);
    hold_check("R2 full duty always active", 20, 4'b0001);
    slot(); setp(4'b1100, 2'b00, 3, 16, 0);
    wait_cyc(40);
    hold_check("R2 duty equal period always active", 20, 4'b0001);

    // R6 / R8 / R9 static patterns
    slot(); cur_tag = "R6";
    setp(4'b1100, 2'b01, 3, 1023, 0); wait_cyc(40);
    hold_check("R6 forward full duty", 8, 4'b1001);
    chk("R6 forward enables", pin_en_o, 4'b1111);
    slot(); cur_tag = "R8";
    setp(4'b1100, 2'b11, 3, 1023, 0); wait_cyc(40);
    hold_check("R8 reverse full duty", 8, 4'b0110);
    slot(); setp(4'b1100, 2'b11, 3, 0, 0); wait_cyc(40);
    hold_check("R8 reverse zero duty", 8, 4'b0100);
    slot(); cur_tag = "R9";
    setp(4'b1111, 2'b00, 3, 0, 0); wait_cyc(40);
    hold_check("R9 single active low idle", 8, 4'b0001);
    slot(); setp(4'b1101, 2'b01, 3, 0, 0); wait_cyc(40);
    hold_check("R9 forward B/D active low", 8, 4'b1011);

    // R7: half bridge dead time 3, duty 16 of 32
    slot(); cur_tag = "R7";
    setp(4'b1100, 2'b10, 7, 16, 3); wait_cyc(80);
    chk("R7 half enables", pin_en_o, 4'b0011);
    wait_edge(1, 1'b0); t1 = cyc_cnt;
    wait_edge(0, 1'b1); t2 = cyc_cnt;
    chk("R7 dead gap B fall to A rise", t2 - t1, 3);
    w = 1;
    forever begin @(negedge clk); if (!pin_o[0]) break; w++; end
    chk("R7 A width after dead time", w, 13);

    // R10 / R11: shutdown with automatic restart
    slot(); cur_tag = "R10";
    setp(4'b1100, 2'b01, 3, 1023, 0); auto_restart_i = 1'b1; wait_cyc(40);
    shut_i = 1'b1; slot();
    @(negedge clk);
    chk("R10 pins inactive on shutdown", pin_o, 4'b0000);
    chk("R10 status set", shut_stat_o, 1);
    slot(); shut_i = 1'b0; cur_tag = "R11";
    wait_cyc(1);
    @(negedge clk);
    chk("R11 status auto clear", shut_stat_o, 0);
    wait_cyc(20);
    @(negedge clk);
    chk("R11 pins resumed", pin_o, 4'b1001);

    // R12: manual restart
    slot(); cur_tag = "R12"; auto_restart_i = 1'b0;
    shut_i = 1'b1; wait_cyc(2); shut_i = 1'b0;
    wait_cyc(40);
    @(negedge clk);
    chk("R12 status sticky", shut_stat_o, 1);
    chk("R12 pins held off", pin_o, 4'b0000);
    slot(); restart_i = 1'b1; slot(); restart_i = 1'b0;
    wait_cyc(20);
    @(negedge clk);
    chk("R12 status cleared by restart", shut_stat_o, 0);
    chk("R12 pins resumed", pin_o, 4'b1001);

    // randomized segments, checked by the cycle model
    for (int seg = 0; seg < 2500; seg++) begin
      logic [3:0] md;
      int per, dut;
      slot();
      per = $urandom_range(0, 12);
      dut = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 1023)
                                        : $urandom_range(0, 4 * (per + 1) + 2);
      md  = ($urandom_range(0, 6) == 0) ? 4'($urandom_range(0, 11))
                                        : {2'b11, 2'($urandom_range(0, 3))};
      setp(md, 2'($urandom_range(0, 3)), per, dut, $urandom_range(0, 6));
      auto_restart_i = $urandom_range(0, 1);
      cur_tag = tag_of(md, bridge_i);
      if ($urandom_range(0, 9) == 0) begin
        cur_tag = "R10";
        shut_i = 1'b1; wait_cyc($urandom_range(1, 3)); shut_i = 1'b0;
      end
      if ($urandom_range(0, 9) == 0) begin
        restart_i = 1'b1; slot(); restart_i = 1'b0;
      end
      wait_cyc($urandom_range(1, 40));
    end

    wait_cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule